// File: doc/BRIEF.md
# Multi-Stage Decimation Sync Controller

This block keeps the decimation phase of three cascaded filter stages aligned: a tuning-oscillator stage, a first integrator-comb stage and a final FIR stage. Each stage owns a modulo counter that runs at that stage's programmed decimation ratio and marks the start of every output period with a one-cycle phase-zero strobe. The counters run freely when no alignment pulse arrives, so a later stage can be aligned by the pulse of an earlier one.

Every stage has one bidirectional sync pad line. When the unit is set up as the pulse source, it drives its own terminal-count strobes onto the three lines. When it is a follower, it leaves the lines undriven and someone outside drives them. In both roles the alignment input is always read back from the pad, so the source unit reacts to its own pulse in exactly the same cycle as every follower. A per-stage mask selects which lines may realign their counters. Software writes the mask into a holding copy, and a separate load strobe moves that copy into the active mask.

Top module: `decim_sync_ctrl`

## Requirements
- R1: After reset the role bit reads 0 (follower), the active and holding masks are 0, and every counter holds 0. With a programmed ratio-minus-one above zero, all phase-zero strobes are therefore low.
- R2: The role bit is written through `role_we`/`role_din` and read back on `role_rd`. When it is 1, each pad line carries that stage's phase-zero strobe. When it is 0, the block does not drive the pads.
- R3: With no effective sync input, a stage with ratio-minus-one M strobes phase-zero once every M+1 cycles. M is the field in bits [8*s+7:8*s] of `dec_m1` for stage s (0 oscillator, 1 integrator-comb, 2 FIR).
- R4: The phase-zero strobe is high for exactly one cycle, while the counter is at its terminal count. The counter returns to 0 on the next clock.
- R5: A pad line that reads 1 at a clock edge while its mask bit is 0 reloads that stage's counter to 0. The stage then strobes phase-zero M cycles later and every M+1 cycles after that.
- R6: A pad line whose active mask bit is 1 has no effect on that stage's counter or strobe.
- R7: `mask_we` writes `mask_wdata` into the holding mask only. `mask_load` copies the holding mask, as it stood before the edge, into the active mask. `mask_rd` always shows the active mask.
- R8: The three lines act independently. Pulses on different lines, with no phase relation among them, realign only their own stages.
- R9: When M is lowered below a stage's current count, that stage takes its terminal count in the current cycle and wraps to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dec_m1 | input | 24 | Per-stage decimation ratio minus one, 8 bits per stage |
| role_we | input | 1 | Role bit write strobe |
| role_din | input | 1 | Role bit value (1 drive pads, 0 listen) |
| role_rd | output | 1 | Current role bit |
| mask_we | input | 1 | Holding-mask write strobe |
| mask_wdata | input | 3 | Holding-mask write value, 1 masks a line |
| mask_load | input | 1 | Copy holding mask to active mask |
| mask_rd | output | 3 | Active mask |
| sync_pad | inout | 3 | Bidirectional sync lines, one per stage |
| phase0 | output | 3 | Per-stage phase-zero strobe |

## Verification
The embedded assertions check the following on every cycle: a stage wraps to 0 after its terminal count, a counter advances by exactly one when nothing interrupts it, an unmasked pad pulse zeroes its counter, the active mask changes only on a load, and the pads follow the internal strobes in driving mode. Other behaviour shows up only in the bench's scenarios. These cover the exact strobe period for each ratio combination, the delay from an outside pulse to the next strobe, the independence of the three lines under unrelated pulse patterns, and the wrap after the ratio is lowered in mid-count. The bench follows these with an arithmetic per-stage phase model, cycle by cycle, across a sweep of small ratios.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  // number of decimation stages sharing the sync scheme
  localparam int NSTG = 3;
  // default counter width per stage
  localparam int CNT_W = 8;
endpackage

// File: rtl/dsync_stage_ctr.sv
module dsync_stage_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ratio_m1,
  input  logic          sync_in,
  input  logic          sync_mask,
  output logic          term
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          reload;

  // next-state logic
  always_comb begin
    term   = (cnt_q >= ratio_m1);
    reload = sync_in & ~sync_mask;
    if (reload || term) cnt_d = '0;
    else                cnt_d = cnt_q + CW'(1);
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r4_term_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (cnt_q == '0));

  a_r5_sync_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !sync_mask) |=> (cnt_q == '0));

  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!term && !(sync_in && !sync_mask)) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/dsync_mask_reg.sv
module dsync_mask_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  input  logic         load,
  output logic [N-1:0] active
);
  logic [N-1:0] shadow_q, shadow_d;
  logic [N-1:0] active_q, active_d;

  always_comb begin
    shadow_d = wr_en ? wr_data  : shadow_q;
    active_d = load  ? shadow_q : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign active = active_q;

  a_r7_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active_q == $past(shadow_q)));

  a_r7_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));
endmodule

// File: rtl/dsync_role_reg.sv
module dsync_role_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic din,
  output logic drive
);
  logic role_q, role_d;

  always_comb role_d = we ? din : role_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) role_q <= 1'b0;
    else        role_q <= role_d;
  end

  assign drive = role_q;

  a_r2_role_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(role_q));
endmodule

// File: rtl/decim_sync_ctrl.sv
module decim_sync_ctrl
  import dsync_pkg::*;
#(
  parameter int N  = NSTG,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N*CW-1:0] dec_m1,
  input  logic          role_we,
  input  logic          role_din,
  output logic          role_rd,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_wdata,
  input  logic          mask_load,
  output logic [N-1:0]  mask_rd,
  inout  wire  [N-1:0]  sync_pad,
  output logic [N-1:0]  phase0
);
  logic         drive;
  logic [N-1:0] act_mask;
  logic [N-1:0] gen_pulse;
  logic [N-1:0] pad_in;

  dsync_role_reg u_role (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (role_we),
    .din   (role_din),
    .drive (drive)
  );

  dsync_mask_reg #(.N(N)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mask_we),
    .wr_data (mask_wdata),
    .load    (mask_load),
    .active  (act_mask)
  );

  // input path is always the pad, so the source unit sees its own pulse
  assign pad_in = sync_pad;

  for (genvar g = 0; g < N; g++) begin : g_stage
    dsync_stage_ctr #(.CW(CW)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ratio_m1  (dec_m1[g*CW +: CW]),
      .sync_in   (pad_in[g]),
      .sync_mask (act_mask[g]),
      .term      (gen_pulse[g])
    );
    assign sync_pad[g] = drive ? gen_pulse[g] : 1'bz;
  end

  assign phase0  = gen_pulse;
  assign mask_rd = act_mask;
  assign role_rd = drive;

  a_r2_pad_follows: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (pad_in == gen_pulse));
endmodule

// File: tb/decim_sync_ctrl_tb.sv
module decim_sync_ctrl_tb;
  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic [2:0][7:0] mv;
  logic       role_we, role_din, role_rd;
  logic       mask_we, mask_load;
  logic [2:0] mask_wdata, mask_rd;
  logic [2:0] phase0;
  logic [2:0] drv_en, drv_val;
  wire  [2:0] pad;

  int total = 0;
  int bad   = 0;
  string tag = "R1";
  bit chk_on = 0;

  for (genvar i = 0; i < 3; i++) begin : g_drv
    assign pad[i] = drv_en[i] ? drv_val[i] : 1'bz;
  end

  decim_sync_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_m1     (mv),
    .role_we    (role_we),
    .role_din   (role_din),
    .role_rd    (role_rd),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .mask_load  (mask_load),
    .mask_rd    (mask_rd),
    .sync_pad   (pad),
    .phase0     (phase0)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  // reference phase model built from the requirements
  int   rc [3];
  logic r_sh_m [3];
  logic [2:0] r_sh, r_act;
  logic r_role;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) rc[i] <= 0;
      r_sh <= 0; r_act <= 0; r_role <= 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (pad[i] === 1'b1 && !r_act[i]) rc[i] <= 0;        // R5, R6, R8
        else if (rc[i] >= int'(mv[i]))     rc[i] <= 0;        // R3, R4, R9
        else                               rc[i] <= rc[i] + 1;
      end
      if (mask_load) r_act <= r_sh;                           // R7
      if (mask_we)   r_sh  <= mask_wdata;
      if (role_we)   r_role <= role_din;                      // R2
    end
  end

  task automatic check(input bit ok, input string t, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      logic [2:0] ep;
      for (int i = 0; i < 3; i++) ep[i] = (rc[i] >= int'(mv[i]));
      check(phase0 == ep, tag, phase0, ep);
      check(mask_rd == r_act, "R7", mask_rd, r_act);
      check(role_rd == r_role, "R2", role_rd, r_role);
      if (r_role && drv_en == 3'b000) check(pad == ep, "R2", pad, ep);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; role_we = 0; role_din = 0; mask_we = 0; mask_load = 0;
    mask_wdata = 0; drv_en = 3'b111; drv_val = 0;
    mv[0] = 3; mv[1] = 3; mv[2] = 3;
    #(CLK_P * 3);
    // R1: reset state with ratios above zero
    check(phase0 == 3'b000, "R1", phase0, 0);
    check(mask_rd == 3'b000, "R1", mask_rd, 0);
    check(role_rd == 1'b0, "R1", role_rd, 0);
    @(negedge clk); rst_n = 1; chk_on = 1;
    tick();
    check(phase0 == 3'b000, "R1", phase0, 0);

    // R3/R4/R9: free run over a sweep of small ratios, changing mid-count
    tag = "R3";
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++) begin
          mv[0] = 8'(a); mv[1] = 8'(b); mv[2] = 8'(c);
          tick(9);
        end
    // R9: lower ratio below current count
    tag = "R9";
    mv = '{8'd7, 8'd7, 8'd7};
    tick(6);
    mv = '{8'd1, 8'd2, 8'd0};
    tick(8);

    // R5/R8: unrelated pulse patterns per line, unmasked
    tag = "R5";
    mv[0] = 4; mv[1] = 2; mv[2] = 5;
    for (int k = 0; k < 90; k++) begin
      for (int i = 0; i < 3; i++) drv_val[i] = ((k * (i + 3)) % (7 + i) == 0);
      tick();
    end
    drv_val = 0;
    tag = "R8";
    for (int k = 0; k < 60; k++) begin
      drv_val = 3'(1 << (k % 3)) & {3{(k % 4) == 1}};
      tick();
    end
    drv_val = 0;

    // R7: write the holding mask without loading
    tag = "R7";
    mask_we = 1; mask_wdata = 3'b101; tick(); mask_we = 0;
    tick();
    check(mask_rd == 3'b000, "R7", mask_rd, 0);
    mask_load = 1; tick(); mask_load = 0;
    check(mask_rd == 3'b101, "R7", mask_rd, 5);
    // R6: pulses on masked lines 0 and 2 must not move their phase
    tag = "R6";
    for (int k = 0; k < 60; k++) begin
      drv_val = ((k % 5) == 2) ? 3'b111 : 3'b000;
      tick();
    end
    drv_val = 0;
    mask_we = 1; mask_wdata = 3'b000; mask_load = 1; tick();
    mask_we = 0; mask_load = 0;
    check(mask_rd == 3'b101, "R7", mask_rd, 5);
    mask_load = 1; tick(); mask_load = 0;
    check(mask_rd == 3'b000, "R7", mask_rd, 0);

    // R2: drive role, pads carry own strobes and resync consistently
    tag = "R2";
    drv_en = 3'b000;
    role_we = 1; role_din = 1; tick(); role_we = 0;
    check(role_rd == 1'b1, "R2", role_rd, 1);
    for (int a = 0; a < 4; a++) begin
      mv[0] = 8'(a); mv[1] = 8'(3 - a); mv[2] = 8'(a + 1);
      tick(12);
    end
    role_we = 1; role_din = 0; tick(); role_we = 0;
    check(role_rd == 1'b0, "R2", role_rd, 0);
    drv_en = 3'b111; drv_val = 3'b010; tick(); drv_val = 0;
    tag = "R8";
    tick(12);

    chk_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule